// File: doc/BRIEF.md
# Transceiver Heartbeat Test Monitor

After each transmitted frame, a healthy transceiver sends back a short heartbeat on its collision path. This block checks for that heartbeat. It counts bit times from the end of transmission. If the heartbeat does not arrive within the observation window, the block reports a collision error as a single-cycle pulse. A bit-time clock enable paces the window, so the block runs from a fast system clock while it measures in network bit times.

The heartbeat rule depends on the attached port type, which is captured when each frame ends:

- On the attachment-unit port, the heartbeat appears on the collision-activity input.
- On the general-purpose serial port, an external encoder/decoder supplies the heartbeat by driving the collision pin.
- On the twisted-pair port, the error depends on the link-fail status rather than on any heartbeat.
- On the direct-attach port, the error is never raised.

Top module: `sqe_monitor`

## Requirements
- R1: The observation window is `WIN_BITS` bit times long (default 20). Its first bit time is the first cycle with `bit_en` high after the cycle in which `tx_end` is high. When an error is due, `sqe_err` is high during the single clock cycle that follows the rising edge which sampled the last bit time of the window.
- R2: With port code 00 (attachment-unit), `coll_act` high on at least one bit time inside the window suppresses the error. Without that, the error pulse is produced. `coll_pin` is ignored on this port.
- R3: Collision activity in the `tx_end` cycle itself, or after the last bit time of the window, does not count as a heartbeat.
- R4: With port code 01 (twisted-pair), the error pulse is produced exactly when `link_fail` is high on the last bit time of the window. Both collision inputs are ignored on this port.
- R5: With port code 10 (general-purpose serial), `coll_pin` high on at least one bit time inside the window suppresses the error. Without that, the error pulse is produced. `coll_act` is ignored on this port.
- R6: With port code 11 (direct-attach), no error pulse is ever produced.
- R7: `port_sel` is captured in the `tx_end` cycle. Changes to `port_sel` during the window have no effect on that frame's result.
- R8: At most one error pulse is produced per frame. A new `tx_end` during an open window abandons the old frame and restarts the window.
- R9: While `rst_n` is low, `sqe_err` is low. A reset during an open window cancels the window, so no pulse follows.
- R10: Only cycles with `bit_en` high count as bit times or sample the heartbeat inputs. Collision activity on cycles with `bit_en` low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle enable marking each network bit time |
| tx_end | input | 1 | Strobe marking the end of a transmitted frame |
| port_sel | input | 2 | Port type: 00 attachment-unit, 01 twisted-pair, 10 general-purpose serial, 11 direct-attach |
| coll_act | input | 1 | Collision-activity indication from the attachment-unit receiver |
| coll_pin | input | 1 | Collision pin driven by an external encoder/decoder |
| link_fail | input | 1 | Twisted-pair link-fail status, high when the link is down |
| sqe_err | output | 1 | Single-cycle collision-error pulse |

## Verification
The checker watches every cycle for the following:
- Every error pulse lasts one cycle and follows the last bit time of a window.
- The verdict on the last bit time matches the port rule: heartbeat seen or not, the link-fail level, or silence on the direct-attach port.
- The output is quiet under reset.

Only the bench scenarios can show the remaining behaviour:
- The exact window length, counted in enables rather than clocks.
- The boundaries of the window: the strobe cycle, the first bit and bit 21.
- The capture of the port code in the strobe cycle.
- The restart on a second strobe and the cancellation by a mid-window reset.

// File: rtl/sqe_mon_pkg.sv
package sqe_mon_pkg;

    typedef enum logic [1:0] {
        PORT_AUI  = 2'b00,
        PORT_TP   = 2'b01,
        PORT_GPSI = 2'b10,
        PORT_DAI  = 2'b11
    } port_e;

    typedef struct packed {
        port_e port;
        logic  seen;
        logic  err;
    } mon_st_t;

endpackage

// File: rtl/sqe_bit_window.sv
module sqe_bit_window #(
    parameter int WIN_BITS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic start,
    output logic active,
    output logic last_bit
);
    localparam int CW = $clog2(WIN_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN_BITS - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active && bit_en) begin
            if (st_q.cnt == LAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active   = st_q.active;
    assign last_bit = st_q.active && bit_en && !start && (st_q.cnt == LAST);

endmodule

// File: rtl/sqe_hb_select.sv
module sqe_hb_select
    import sqe_mon_pkg::*;
(
    input  port_e port,
    input  logic  coll_act,
    input  logic  coll_pin,
    input  logic  link_fail,
    input  logic  seen_prior,
    output logic  hb,
    output logic  fail
);
    always_comb begin
        hb   = 1'b0;
        fail = 1'b0;
        case (port)
            PORT_AUI: begin
                hb   = coll_act;
                fail = !(seen_prior || coll_act);
            end
            PORT_TP: begin
                fail = link_fail;
            end
            PORT_GPSI: begin
                hb   = coll_pin;
                fail = !(seen_prior || coll_pin);
            end
            default: begin
                hb   = 1'b0;
                fail = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sqe_monitor.sv
module sqe_monitor
    import sqe_mon_pkg::*;
#(
    parameter int WIN_BITS = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       tx_end,
    input  logic [1:0] port_sel,
    input  logic       coll_act,
    input  logic       coll_pin,
    input  logic       link_fail,
    output logic       sqe_err
);
    mon_st_t    st_d, st_q;
    logic       win_active;
    logic       win_last;
    logic       hb;
    logic       fail;
    logic       seen_any;
    logic [1:0] port_q;

    sqe_bit_window #(
        .WIN_BITS (WIN_BITS)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .start    (tx_end),
        .active   (win_active),
        .last_bit (win_last)
    );

    sqe_hb_select u_sel (
        .port       (st_q.port),
        .coll_act   (coll_act),
        .coll_pin   (coll_pin),
        .link_fail  (link_fail),
        .seen_prior (st_q.seen),
        .hb         (hb),
        .fail       (fail)
    );

    assign seen_any = st_q.seen || hb;
    assign port_q   = st_q.port;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (tx_end) begin
            st_d.port = port_e'(port_sel);
            st_d.seen = 1'b0;
        end else if (win_active && bit_en) begin
            st_d.seen = seen_any;
        end
        if (win_last) begin
            st_d.err = fail;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sqe_err = st_q.err;

endmodule

// File: rtl/sqe_monitor_chk.sv
module sqe_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       win_last,
    input logic [1:0] port_q,
    input logic       seen_any,
    input logic       link_fail,
    input logic       sqe_err
);
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sqe_err |=> !sqe_err);

    a_r1_after_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
        sqe_err |-> $past(win_last));

    a_r6_dai_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (win_last && port_q == 2'b11) |=> !sqe_err);

    a_r2_heartbeat_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (win_last && !port_q[0] && seen_any) |=> !sqe_err);

    a_r5_missing_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (win_last && !port_q[0] && !seen_any) |=> sqe_err);

    a_r4_link_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (win_last && port_q == 2'b01) |=> (sqe_err == $past(link_fail)));

    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !sqe_err);

endmodule

bind sqe_monitor sqe_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_last  (win_last),
    .port_q    (port_q),
    .seen_any  (seen_any),
    .link_fail (link_fail),
    .sqe_err   (sqe_err)
);

// File: tb/sim_sqe_monitor.sv
`timescale 1ns/1ps
module sim_sqe_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       tx_end = 1'b0;
    logic [1:0] port_sel = 2'b00;
    logic       coll_act = 1'b0;
    logic       coll_pin = 1'b0;
    logic       link_fail = 1'b0;
    logic       sqe_err;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    sqe_monitor #(.WIN_BITS(20)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .tx_end    (tx_end),
        .port_sel  (port_sel),
        .coll_act  (coll_act),
        .coll_pin  (coll_pin),
        .link_fail (link_fail),
        .sqe_err   (sqe_err)
    );

    // src: 0 none, 1 coll_act, 2 coll_pin; heartbeat on bits lo..hi
    typedef struct packed {
        logic [1:0] port;
        logic [1:0] src;
        logic [5:0] lo;
        logic [5:0] hi;
        logic       lf;
        logic       exp;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 2'd1, 6'd8,  6'd17, 1'b0, 1'b0, 4'd2},  // R2 heartbeat mid window
        '{2'b00, 2'd0, 6'd0,  6'd0,  1'b0, 1'b1, 4'd2},  // R2 no heartbeat
        '{2'b00, 2'd1, 6'd20, 6'd20, 1'b0, 1'b0, 4'd3},  // R3 last bit still inside
        '{2'b00, 2'd1, 6'd21, 6'd25, 1'b0, 1'b1, 4'd3},  // R3 late heartbeat
        '{2'b00, 2'd2, 6'd5,  6'd14, 1'b0, 1'b1, 4'd2},  // R2 pin ignored on AUI
        '{2'b01, 2'd1, 6'd3,  6'd12, 1'b1, 1'b1, 4'd4},  // R4 link down
        '{2'b01, 2'd0, 6'd0,  6'd0,  1'b0, 1'b0, 4'd4},  // R4 link up
        '{2'b01, 2'd2, 6'd2,  6'd6,  1'b0, 1'b0, 4'd4},  // R4 pin ignored
        '{2'b10, 2'd2, 6'd4,  6'd6,  1'b0, 1'b0, 4'd5},  // R5 pin heartbeat
        '{2'b10, 2'd1, 6'd4,  6'd13, 1'b0, 1'b1, 4'd5},  // R5 activity ignored
        '{2'b10, 2'd0, 6'd0,  6'd0,  1'b0, 1'b1, 4'd5},  // R5 missing
        '{2'b11, 2'd0, 6'd0,  6'd0,  1'b1, 1'b0, 4'd6},  // R6 never reported
        '{2'b00, 2'd1, 6'd1,  6'd1,  1'b0, 1'b0, 4'd1}   // R1 first bit counts
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One frame; port_sel is inverted after the strobe (R7 capture).
    task automatic frame(input logic [1:0] port, input int src, input int lo, input int hi,
                         input logic lf, input int per, input int restart_at, input int rst_at,
                         input bit hb_strobe, input bit hb_off_en, input bit exp,
                         input string req);
        int nb = 0;
        int c20 = -1;
        int npulse = 0;
        int c_at = -1;
        @(negedge clk);
        port_sel = port; tx_end = 1'b1; bit_en = 1'b0; link_fail = lf;
        coll_act = hb_strobe; coll_pin = hb_strobe;
        @(posedge clk);
        for (int c = 1; c <= 25 * per + 10; c++) begin
            @(negedge clk);
            rst_n = 1'b1;
            tx_end = 1'b0;
            port_sel = ~port;
            bit_en = ((c % per) == 0);
            if (c == restart_at) begin
                tx_end = 1'b1; bit_en = 1'b0; nb = 0; c20 = -1;
                port_sel = port;
            end
            if (c == rst_at) rst_n = 1'b0;
            if (bit_en) nb++;
            if (bit_en && nb == 20) c20 = c;
            coll_act = 1'b0; coll_pin = 1'b0;
            if (hb_off_en) begin
                coll_act = !bit_en; coll_pin = !bit_en;
            end else if (bit_en && nb >= lo && nb <= hi) begin
                if (src == 1) coll_act = 1'b1;
                if (src == 2) coll_pin = 1'b1;
            end
            @(posedge clk);
            #1;
            if (sqe_err === 1'b1) begin
                npulse++;
                if (c_at < 0) c_at = c;
            end
        end
        @(negedge clk);
        rst_n = 1'b1; bit_en = 1'b0; coll_act = 1'b0; coll_pin = 1'b0;
        check(npulse == (exp ? 1 : 0), {req, " pulse count"}, npulse, exp ? 1 : 0);
        if (exp) check(c_at == c20, {req, " pulse cycle"}, c_at, c20);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sqe_err === 1'b0, "R9 reset state", int'(sqe_err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            frame(VEC[v].port, int'(VEC[v].src), int'(VEC[v].lo), int'(VEC[v].hi),
                  VEC[v].lf, 1, -1, -1, 1'b0, 1'b0, VEC[v].exp,
                  $sformatf("R%0d vec%0d", VEC[v].rq, v));
        end

        // R7: strobe with DAI, switched to AUI in window with no heartbeat
        frame(2'b11, 0, 0, 0, 1'b0, 1, -1, -1, 1'b0, 1'b0, 1'b0, "R7 port latched");
        // R7: strobe with AUI, switched to DAI in window, must still flag
        frame(2'b00, 0, 0, 0, 1'b0, 1, -1, -1, 1'b0, 1'b0, 1'b1, "R7 port latched aui");
        // R3: activity only during the strobe cycle
        frame(2'b00, 0, 0, 0, 1'b0, 1, -1, -1, 1'b1, 1'b0, 1'b1, "R3 strobe cycle");
        // R10: sparse enable, window counted in enables
        frame(2'b00, 0, 0, 0, 1'b0, 3, -1, -1, 1'b0, 1'b0, 1'b1, "R10 sparse enable");
        // R10: activity only on non-enable cycles
        frame(2'b00, 0, 0, 0, 1'b0, 3, -1, -1, 1'b0, 1'b1, 1'b1, "R10 off-enable activity");
        // R10: sparse enable with heartbeat on an enabled bit
        frame(2'b10, 2, 19, 19, 1'b0, 2, -1, -1, 1'b0, 1'b0, 1'b0, "R10 sparse heartbeat");
        // R8: second strobe restarts the window, one pulse only
        frame(2'b00, 0, 0, 0, 1'b0, 1, 11, -1, 1'b0, 1'b0, 1'b1, "R8 restart");
        // R9: reset mid window cancels the frame
        frame(2'b00, 0, 0, 0, 1'b0, 1, -1, 10, 1'b0, 1'b0, 1'b0, "R9 mid-window reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule